// File: doc/BRIEF.md
# Prescaled Watchdog Reset Timer

This block supervises software liveness from a slow 32.768 kHz reference clock. A free-running binary prescaler turns the reference into a slow tick (4 Hz with the default 13-bit width). A small tick counter measures how many ticks have gone by since software last serviced the watchdog. When the configured number of ticks passes with no service, the block drives a reset pulse that lasts a fixed number of tick periods.

Software services the watchdog by writing the service register. The register decode outside this block turns that write into a single-cycle strobe that is synchronous to the reference clock. The prescaler phase is never realigned by a service. The delay from a service to a timeout therefore falls in a window one tick wide: between 500 ms and 750 ms with the defaults. An enable input turns the whole mechanism on or off. A synchronous power-on reset puts the block into the idle, not-timed-out state.

Top module: `wdt_reset_timer`

## Requirements
- R1: While `por` is high, `rst_out` is 0 and the prescaler is held at phase zero. After `por` falls, the first tick is counted at the N-th rising edge, counting from the first edge that samples `por` low as edge 0 (so at edge N-1), where N = 2^PRESC_W.
- R2: The prescaler runs freely with period N. Ticks are counted at edges N-1, 2N-1, 3N-1 and so on after `por` release, whatever the service strobe, enable or reset pulse do.
- R3: A timeout fires at the edge that samples the TIMEOUT_TICKS-th tick (default 3) since the last clear, provided no service is sampled at that edge. `rst_out` reads 1 right after that edge.
- R4: A sampled `svc_stb` clears the tick count. If the service and a tick fall on the same edge, the service wins and that tick is not counted.
- R5: With the defaults, the timeout follows a service by between 2N+1 and 3N reference cycles. The delay depends only on where the service falls relative to the tick phase.
- R6: `rst_out` stays high for exactly PULSE_TICKS·N cycles (default N). It falls at the edge that samples the PULSE_TICKS-th tick after the rise.
- R7: When the pulse ends, the tick count restarts from zero, exactly as after a service.
- R8: A service strobe sampled while `rst_out` is high has no effect: the pulse does not shorten and the next timeout is unchanged.
- R9: An edge that samples `wd_en` low clears `rst_out` and the tick count. No reset pulse is produced while `wd_en` stays low.
- R10: After `wd_en` returns high, counting starts from zero on the free-running tick phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 32.768 kHz reference clock |
| por | input | 1 | Synchronous active-high power-on reset |
| wd_en | input | 1 | Watchdog enable, 1 = active |
| svc_stb | input | 1 | Single-cycle service strobe from the register write |
| rst_out | output | 1 | Registered active-high reset pulse |

## Verification
A corrupted tick count shows up at `rst_out` as a pulse edge that is early or late by a whole number of tick periods. It becomes visible within at most TIMEOUT_TICKS·N cycles of the fault. A prescaler that is off in phase moves every rise and fall by the same offset, so the very first timeout exposes it. A wrong priority between the service and the tick makes a timeout land one tick early or late. Faulty handling of a service during the pulse, or of the enable, shows up as a wrong fall time on the pulse it touches.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [0:0] {
    WD_WATCH = 1'b0,
    WD_PULSE = 1'b1
  } wd_state_e;

  function automatic int unsigned cnt_width(input int unsigned maxval);
    return (maxval > 1) ? $clog2(maxval) : 1;
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned PRESC_W = 13
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam logic [PRESC_W-1:0] PRE_LAST = {PRESC_W{1'b1}};

  logic [PRESC_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      tick_o  <= 1'b0;
    end else begin
      phase_q <= phase_q + 1'b1;
      tick_o  <= (phase_q == PRE_LAST - 1'b1);
    end
  end

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
  parameter int unsigned TIMEOUT_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic svc,
  input  logic tick,
  input  logic hold,
  output logic fire_o
);
  import wdt_pkg::*;
  localparam int unsigned CNT_W = cnt_width(TIMEOUT_TICKS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_TICKS - 1);

  logic [CNT_W-1:0] ticks_q;

  always_ff @(posedge clk) begin
    if (rst || !en || hold || svc) begin
      ticks_q <= '0;
    end else if (tick) begin
      ticks_q <= (ticks_q == CNT_LAST) ? '0 : ticks_q + 1'b1;
    end
  end

  assign fire_o = en && !hold && !svc && tick && (ticks_q == CNT_LAST);

  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    ticks_q <= CNT_LAST);
  // R4
  svc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (svc && en) |=> (ticks_q == '0));
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int unsigned PULSE_TICKS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic fire,
  output logic active_o
);
  import wdt_pkg::*;
  localparam int unsigned PCNT_W = cnt_width(PULSE_TICKS);
  localparam logic [PCNT_W-1:0] PCNT_LAST = PCNT_W'(PULSE_TICKS - 1);

  wd_state_e         state_q;
  logic [PCNT_W-1:0] pcnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state_q  <= WD_WATCH;
      pcnt_q   <= '0;
      active_o <= 1'b0;
    end else begin
      case (state_q)
        WD_WATCH: begin
          if (fire) begin
            state_q  <= WD_PULSE;
            pcnt_q   <= '0;
            active_o <= 1'b1;
          end
        end
        WD_PULSE: begin
          if (tick) begin
            if (pcnt_q == PCNT_LAST) begin
              state_q  <= WD_WATCH;
              active_o <= 1'b0;
            end else begin
              pcnt_q <= pcnt_q + 1'b1;
            end
          end
        end
        default: state_q <= WD_WATCH;
      endcase
    end
  end

  // R3
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active_o) |-> $past(tick));
  // R6
  pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active_o && en && !tick) |=> active_o);
endmodule

// File: rtl/wdt_reset_timer.sv
module wdt_reset_timer #(
  parameter int unsigned PRESC_W       = 13,
  parameter int unsigned TIMEOUT_TICKS = 3,
  parameter int unsigned PULSE_TICKS   = 1
) (
  input  logic clk_ref,
  input  logic por,
  input  logic wd_en,
  input  logic svc_stb,
  output logic rst_out
);
  logic tick;
  logic fire;

  wdt_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk    (clk_ref),
    .rst    (por),
    .tick_o (tick)
  );

  wdt_tick_counter #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_count (
    .clk    (clk_ref),
    .rst    (por),
    .en     (wd_en),
    .svc    (svc_stb),
    .tick   (tick),
    .hold   (rst_out),
    .fire_o (fire)
  );

  wdt_pulse_gen #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk      (clk_ref),
    .rst      (por),
    .en       (wd_en),
    .tick     (tick),
    .fire     (fire),
    .active_o (rst_out)
  );

  // R9
  disable_clear_chk: assert property (@(posedge clk_ref) disable iff (por)
    !wd_en |=> !rst_out);
  // R8
  svc_ignored_chk: assert property (@(posedge clk_ref) disable iff (por)
    (rst_out && svc_stb && wd_en && !tick) |=> rst_out);
endmodule

// File: tb/sim_wdt_reset_timer.sv
module sim_wdt_reset_timer;
  localparam int unsigned PW = 4;   // N = 16 cycles per tick

  typedef struct {
    bit rise;
    int cyc;
    string req;
  } ev_t;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic wd_en = 1'b1;
  logic svc_stb = 1'b0;
  logic rst_out;

  int cyc = -1;
  int checks = 0;
  int errors = 0;
  logic prev_rst = 1'b0;
  ev_t exp_q[$];

  wdt_reset_timer #(.PRESC_W(PW), .TIMEOUT_TICKS(3), .PULSE_TICKS(1)) u0 (
    .clk_ref (clk_ref_w),
    .por     (por),
    .wd_en   (wd_en),
    .svc_stb (svc_stb),
    .rst_out (rst_out)
  );
  wire clk_ref_w = clk;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (por) cyc <= -1;
    else     cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cyc %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic expect_ev(input bit rise, input int c, input string req);
    ev_t e;
    e.rise = rise; e.cyc = c; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wait_cyc(input int c);
    while (cyc != c) @(negedge clk);
  endtask

  task automatic svc_at(input int s);
    wait_cyc(s - 1);
    svc_stb = 1'b1;
    @(negedge clk);
    svc_stb = 1'b0;
  endtask

  task automatic en_at(input int s, input bit v);
    wait_cyc(s - 1);
    wd_en = v;
  endtask

  // monitor: compares every rst_out transition against the scoreboard
  always @(negedge clk) begin
    if (!por && rst_out !== prev_rst) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", cyc, -1);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        check(rst_out == e.rise && cyc == e.cyc, e.req, cyc, e.cyc);
      end
    end
    prev_rst = rst_out;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check(rst_out == 1'b0, "R1", int'(rst_out), 0);
    por = 1'b0;
    // R1 R2 R3: first timeout at third tick (edges 15, 31, 47)
    expect_ev(1'b1, 47, "R3");
    // R6: pulse lasts one tick
    expect_ev(1'b0, 63, "R6");
    // R8: service during pulse ignored
    svc_at(55);
    check(rst_out == 1'b1, "R8", int'(rst_out), 1);
    // R7: restart after pulse; R4: service clears; service on tick edge wins
    svc_at(100);
    svc_at(143);
    expect_ev(1'b1, 191, "R5");   // max window 3N after service at 143
    expect_ev(1'b0, 207, "R6");
    svc_at(254);
    expect_ev(1'b1, 287, "R5");   // min window 2N+1 after service at 254
    expect_ev(1'b0, 303, "R6");
    // R4: periodic service prevents timeout
    svc_at(320);
    svc_at(352);
    svc_at(384);
    svc_at(416);
    expect_ev(1'b1, 463, "R4");
    expect_ev(1'b0, 479, "R7");
    // R9: disabled, no pulse
    en_at(490, 1'b0);
    wait_cyc(600);
    check(rst_out == 1'b0, "R9", int'(rst_out), 0);
    // R10: re-enable restarts count from zero on free-running phase
    en_at(610, 1'b1);
    expect_ev(1'b1, 655, "R10");
    // R9: disable mid-pulse clears at once
    expect_ev(1'b0, 660, "R9");
    en_at(660, 1'b0);
    en_at(700, 1'b1);
    expect_ev(1'b1, 735, "R2");
    expect_ev(1'b0, 751, "R6");
    wait_cyc(770);
    check(exp_q.size() == 0, "R2", exp_q.size(), 0);
    check(rst_out == 1'b0, "R7", int'(rst_out), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 770);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule